// File: doc/BRIEF.md
# Next Program Counter Unit

This block decides where a small 32-bit core fetches its next instruction. It holds the program counter in a register, reports the instruction-memory word index taken from that register, and works out the next value from the current instruction word, the two source operand values read for it, and an error flag raised by the decoder. Every clock edge retires one instruction until the program finishes.

The supported control transfers are plain sequential fetch, an absolute jump, a jump that also saves a return address into register 31, an indirect jump through the first operand, and three conditional branches. Branch targets are taken relative to the address of the branch itself, not the following word. Absolute jump targets keep only the 26-bit field shifted left by two, so the upper address bits become zero. A next value of zero marks the end of the program: once the register holds zero the unit reports halted, freezes, and waits for reset. A retired-instruction counter tracks how many instructions ran, counting the one that ended the program.

Top module: `npc_unit`

## Requirements
- R1: While rstN is low and after its release, pcOut is 0x00400000, retired is 0 and halted is 0.
- R2: For an opcode (instrWord[31:26]) outside 1 to 5 that is not an indirect jump, nextPc is pcOut + 4, and on the next edge pcOut takes the value nextPc showed.
- R3: imemIndex always equals pcOut[7:2].
- R4: Opcode 2 gives nextPc = {4'b0, instrWord[25:0], 2'b00}.
- R5: Opcode 3 gives the same target as opcode 2 and raises linkEn with linkVal = pcOut + 4; for every other case linkEn is 0.
- R6: Opcode 0 with instrWord[5:0] = 8 gives nextPc = rsVal.
- R7: Opcode 4 (taken when rsVal equals rtVal) and opcode 5 (taken when they differ) give nextPc = pcOut + (sign-extended instrWord[15:0] shifted left by 2) when taken and pcOut + 4 otherwise.
- R8: Opcode 1 is taken exactly when rsVal[31] is 0, with the same target rule as R7.
- R9: decodeErr high forces nextPc to 0 whatever the instruction, and keeps linkEn at 0.
- R10: When pcOut is loaded with 0, halted rises on that edge and stays high until reset; while halted, pcOut stays 0, nextPc equals pcOut and linkEn is 0.
- R11: retired increases by one on every edge while not halted, including the edge that halts, and holds while halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instrWord | input | 32 | Instruction at the current PC |
| rsVal | input | 32 | First source operand value |
| rtVal | input | 32 | Second source operand value |
| decodeErr | input | 1 | Decoder found an illegal instruction |
| pcOut | output | 32 | Registered program counter |
| imemIndex | output | 6 | Instruction memory word index |
| nextPc | output | 32 | Value the PC takes on the next edge |
| linkVal | output | 32 | Return address to write into register 31 |
| linkEn | output | 1 | Return address write enable |
| halted | output | 1 | Program has finished |
| retired | output | 32 | Retired instruction count |

## Verification
nextPc, linkVal, linkEn and imemIndex are combinational in the current PC and the inputs, so the bench drives a new instruction just after a falling edge and compares them a few nanoseconds later in the same cycle. pcOut, halted and retired change only on the following rising edge, so they are compared at the next falling edge against a model state updated once per instruction. Random instruction streams with a fixed seed are mixed with directed cases for extreme jump fields, backward branches, sign boundaries, errors and the frozen halted state.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_BGEZ    = 6'd1;
  localparam logic [5:0] OP_JUMP    = 6'd2;
  localparam logic [5:0] OP_CALL    = 6'd3;
  localparam logic [5:0] OP_BEQ     = 6'd4;
  localparam logic [5:0] OP_BNE     = 6'd5;
  localparam logic [5:0] FN_JREG    = 6'd8;

  typedef enum logic [2:0] {
    PC_SEQ    = 3'd0,
    PC_JUMP   = 3'd1,
    PC_REG    = 3'd2,
    PC_BRANCH = 3'd3,
    PC_ZERO   = 3'd4,
    PC_HOLD   = 3'd5
  } pcSel_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   linkWrite;
    logic   advance;
  } npcStrobe_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       operandsEq,
  input  logic       rsNonNeg,
  input  logic       decodeErr,
  input  logic       haltState,
  output npcStrobe_t strobe
);

  logic branchTaken;

  always_comb begin
    unique case (opcode)
      OP_BEQ:  branchTaken = operandsEq;
      OP_BNE:  branchTaken = !operandsEq;
      OP_BGEZ: branchTaken = rsNonNeg;
      default: branchTaken = 1'b0;
    endcase
  end

  always_comb begin
    strobe.pcSel     = PC_SEQ;
    strobe.linkWrite = 1'b0;
    strobe.advance   = !haltState;
    if (haltState) begin
      strobe.pcSel = PC_HOLD;
    end else if (decodeErr) begin
      strobe.pcSel = PC_ZERO;
    end else begin
      case (opcode)
        OP_JUMP: strobe.pcSel = PC_JUMP;
        OP_CALL: begin
          strobe.pcSel     = PC_JUMP;
          strobe.linkWrite = 1'b1;
        end
        OP_SPECIAL: if (funct == FN_JREG) strobe.pcSel = PC_REG;
        OP_BEQ, OP_BNE, OP_BGEZ: if (branchTaken) strobe.pcSel = PC_BRANCH;
        default: strobe.pcSel = PC_SEQ;
      endcase
    end
  end

  // R5
  link_only_call_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.linkWrite |-> (opcode == OP_CALL && !decodeErr && !haltState));

  // R9
  err_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decodeErr && !haltState) |-> (strobe.pcSel == PC_ZERO && !strobe.linkWrite));

endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 16,
  parameter int JFIELD_W = 26,
  parameter int IDX_W    = 6,
  parameter int CNT_W    = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  npcStrobe_t          strobe,
  input  logic [JFIELD_W-1:0] jumpField,
  input  logic [IMM_W-1:0]    immField,
  input  logic [XLEN-1:0]     rsVal,
  input  logic [XLEN-1:0]     rtVal,
  output logic                operandsEq,
  output logic                rsNonNeg,
  output logic                haltState,
  output logic [XLEN-1:0]     pcOut,
  output logic [IDX_W-1:0]    imemIndex,
  output logic [XLEN-1:0]     nextPc,
  output logic [XLEN-1:0]     linkVal,
  output logic                linkEn,
  output logic [CNT_W-1:0]    retired
);

  localparam int WORD_SHIFT = 2;
  localparam int JPAD_W     = XLEN - JFIELD_W - WORD_SHIFT;
  localparam int SEXT_W     = XLEN - IMM_W - WORD_SHIFT;
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(1 << WORD_SHIFT);

  logic [XLEN-1:0] pcReg, seqPc, jumpTgt, branchTgt, branchOfs;
  logic            haltReg;
  logic [CNT_W-1:0] retiredReg;

  assign operandsEq = (rsVal == rtVal);
  assign rsNonNeg   = !rsVal[XLEN-1];

  assign seqPc     = pcReg + WORD_BYTES;
  assign jumpTgt   = {{JPAD_W{1'b0}}, jumpField, {WORD_SHIFT{1'b0}}};
  assign branchOfs = {{SEXT_W{immField[IMM_W-1]}}, immField, {WORD_SHIFT{1'b0}}};
  assign branchTgt = pcReg + branchOfs;

  always_comb begin
    unique case (strobe.pcSel)
      PC_JUMP:   nextPc = jumpTgt;
      PC_REG:    nextPc = rsVal;
      PC_BRANCH: nextPc = branchTgt;
      PC_ZERO:   nextPc = '0;
      PC_HOLD:   nextPc = pcReg;
      default:   nextPc = seqPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg      <= RESET_PC;
      haltReg    <= 1'b0;
      retiredReg <= '0;
    end else if (strobe.advance) begin
      pcReg      <= nextPc;
      haltReg    <= (nextPc == '0);
      retiredReg <= retiredReg + 1'b1;
    end
  end

  assign pcOut     = pcReg;
  assign haltState = haltReg;
  assign imemIndex = pcReg[WORD_SHIFT +: IDX_W];
  assign linkVal   = seqPc;
  assign linkEn    = strobe.linkWrite;
  assign retired   = retiredReg;

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltReg |=> haltReg);

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltReg |=> ($stable(pcReg) && !linkEn));

  // R10
  halt_on_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!haltReg && nextPc == '0) |=> haltReg);

  // R2
  pc_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !haltReg |=> (pcReg == $past(nextPc)));

  // R11
  retire_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !haltReg |=> (retiredReg == $past(retiredReg) + 1'b1));

  // R11
  retire_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltReg |=> $stable(retiredReg));

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 6,
  parameter int CNT_W = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [XLEN-1:0]  instrWord,
  input  logic [XLEN-1:0]  rsVal,
  input  logic [XLEN-1:0]  rtVal,
  input  logic             decodeErr,
  output logic [XLEN-1:0]  pcOut,
  output logic [IDX_W-1:0] imemIndex,
  output logic [XLEN-1:0]  nextPc,
  output logic [XLEN-1:0]  linkVal,
  output logic             linkEn,
  output logic             halted,
  output logic [CNT_W-1:0] retired
);

  localparam int OP_W     = 6;
  localparam int IMM_W    = 16;
  localparam int JFIELD_W = XLEN - OP_W;

  npcStrobe_t strobe;
  logic       operandsEq, rsNonNeg, haltState;

  npc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opcode     (instrWord[XLEN-1 -: OP_W]),
    .funct      (instrWord[OP_W-1:0]),
    .operandsEq (operandsEq),
    .rsNonNeg   (rsNonNeg),
    .decodeErr  (decodeErr),
    .haltState  (haltState),
    .strobe     (strobe)
  );

  npc_datapath #(
    .XLEN     (XLEN),
    .IMM_W    (IMM_W),
    .JFIELD_W (JFIELD_W),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .jumpField  (instrWord[JFIELD_W-1:0]),
    .immField   (instrWord[IMM_W-1:0]),
    .rsVal      (rsVal),
    .rtVal      (rtVal),
    .operandsEq (operandsEq),
    .rsNonNeg   (rsNonNeg),
    .haltState  (haltState),
    .pcOut      (pcOut),
    .imemIndex  (imemIndex),
    .nextPc     (nextPc),
    .linkVal    (linkVal),
    .linkEn     (linkEn),
    .retired    (retired)
  );

  assign halted = haltState;

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decodeErr && !halted) |-> (nextPc == '0));

  // R1
  reset_value_chk: assert property (@(posedge clk)
    !rstN |=> (pcOut == RESET_PC && !halted && retired == '0));

endmodule

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;

  localparam int PERIOD = 20;
  localparam logic [31:0] RST_PC = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrWord = '0, rsVal = '0, rtVal = '0;
  logic        decodeErr = 1'b0;
  logic [31:0] pcOut, nextPc, linkVal, retired;
  logic [5:0]  imemIndex;
  logic        linkEn, halted;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mPc, mCnt;
  logic        mHalt;

  always #(PERIOD/2) clk = ~clk;

  npc_unit u_npc_unit (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .rsVal(rsVal),
    .rtVal(rtVal), .decodeErr(decodeErr), .pcOut(pcOut),
    .imemIndex(imemIndex), .nextPc(nextPc), .linkVal(linkVal),
    .linkEn(linkEn), .halted(halted), .retired(retired)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelNext(input logic [31:0] pc, input logic [31:0] ins,
      input logic [31:0] rs, input logic [31:0] rt, input logic err, input logic hlt);
    logic [31:0] br;
    br = pc + {{14{ins[15]}}, ins[15:0], 2'b00};
    if (hlt) return pc;
    if (err) return 32'd0;
    case (ins[31:26])
      6'd2, 6'd3: return {4'b0, ins[25:0], 2'b00};
      6'd0:       return (ins[5:0] == 6'd8) ? rs : pc + 32'd4;
      6'd4:       return (rs == rt) ? br : pc + 32'd4;
      6'd5:       return (rs != rt) ? br : pc + 32'd4;
      6'd1:       return (!rs[31]) ? br : pc + 32'd4;
      default:    return pc + 32'd4;
    endcase
  endfunction

  function automatic string reqOf(input logic [31:0] ins, input logic err, input logic hlt);
    if (hlt) return "R10";
    if (err) return "R9";
    case (ins[31:26])
      6'd2: return "R4";
      6'd3: return "R5";
      6'd0: return (ins[5:0] == 6'd8) ? "R6" : "R2";
      6'd4, 6'd5: return "R7";
      6'd1: return "R8";
      default: return "R2";
    endcase
  endfunction

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic runInstr(input logic [31:0] ins, input logic [31:0] rs,
                          input logic [31:0] rt, input logic err);
    logic [31:0] exp;
    logic        expLink;
    instrWord = ins; rsVal = rs; rtVal = rt; decodeErr = err;
    #2;
    exp = modelNext(mPc, ins, rs, rt, err, mHalt);
    expLink = !mHalt && !err && ins[31:26] == 6'd3;
    chk(reqOf(ins, err, mHalt), nextPc, exp);
    chk("R5 linkEn", {31'd0, linkEn}, {31'd0, expLink});
    if (expLink) chk("R5 linkVal", linkVal, mPc + 32'd4);
    chk("R3", {26'd0, imemIndex}, {26'd0, mPc[7:2]});
    @(negedge clk);
    if (!mHalt) begin
      mPc = exp;
      mCnt = mCnt + 32'd1;
      if (exp == 32'd0) mHalt = 1'b1;
    end
    chk("R2 pcOut", pcOut, mPc);
    chk("R10 halted", {31'd0, halted}, {31'd0, mHalt});
    chk("R11 retired", retired, mCnt);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pc during reset", pcOut, RST_PC);
    rstN = 1'b1;
    mPc = RST_PC; mCnt = '0; mHalt = 1'b0;
    chk("R1 pc", pcOut, RST_PC);
    chk("R1 retired", retired, 32'd0);
    chk("R1 halted", {31'd0, halted}, 32'd0);
  endtask

  function automatic logic [31:0] randInstr();
    logic [31:0] w;
    w = $urandom;
    case ($urandom % 8)
      0: w[31:26] = 6'd2;
      1: w[31:26] = 6'd3;
      2: begin w[31:26] = 6'd0; w[5:0] = 6'd8; end
      3: w[31:26] = 6'd4;
      4: w[31:26] = 6'd5;
      5: w[31:26] = 6'd1;
      6: begin w[31:26] = 6'd0; if (w[5:0] == 6'd8) w[5:0] = 6'd33; end
      default: w[31:26] = 6'(6 + ($urandom % 58));
    endcase
    return w;
  endfunction

  initial begin
    #(PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    mPc = RST_PC; mCnt = '0; mHalt = 1'b0;
    doReset();

    // R2 sequential, ordinary arithmetic opcode
    runInstr({6'd0, 20'h12345, 6'd33}, 32'd1, 32'd2, 1'b0);
    runInstr({6'd9, 26'h0000007}, 32'd0, 32'd0, 1'b0);
    // R7 backward branch: offset -1 lands on own address minus 4
    runInstr({6'd4, 5'd1, 5'd2, 16'hFFFF}, 32'd5, 32'd5, 1'b0);
    // R7 BNE not taken
    runInstr({6'd5, 5'd1, 5'd2, 16'h0010}, 32'd7, 32'd7, 1'b0);
    // R8 BGEZ boundaries
    runInstr({6'd1, 5'd3, 5'd1, 16'h0004}, 32'd0, 32'd0, 1'b0);
    runInstr({6'd1, 5'd3, 5'd1, 16'h0004}, 32'h8000_0000, 32'd0, 1'b0);
    runInstr({6'd1, 5'd3, 5'd1, 16'h8000}, 32'h7FFF_FFFF, 32'd0, 1'b0);
    // R4 full jump field drops upper bits
    runInstr({6'd2, 26'h3FF_FFFF}, 32'd0, 32'd0, 1'b0);
    // R5 call
    runInstr({6'd3, 26'h010_0040}, 32'd0, 32'd0, 1'b0);
    // R6 indirect jump
    runInstr({6'd0, 5'd31, 15'd0, 6'd8}, 32'h0040_0100, 32'd0, 1'b0);
    // R9 error on a call: zero target, no link, halts
    runInstr({6'd3, 26'h000_1234}, 32'd0, 32'd0, 1'b1);
    // R10 frozen while halted
    runInstr({6'd3, 26'h000_5555}, 32'd0, 32'd0, 1'b0);
    runInstr({6'd0, 5'd4, 15'd0, 6'd8}, 32'h1234_5678, 32'd0, 1'b0);
    doReset();
    // R10 indirect jump to zero halts
    runInstr({6'd0, 5'd4, 15'd0, 6'd8}, 32'd0, 32'd0, 1'b0);
    runInstr({6'd2, 26'h000_0100}, 32'd0, 32'd0, 1'b0);
    doReset();

    for (int i = 0; i < 3000; i++) begin
      r = $urandom;
      runInstr(randInstr(), r, ($urandom % 2 == 0) ? r : $urandom,
               ($urandom % 97) == 0);
      if (mHalt && ($urandom % 3 == 0)) doReset();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule